// File: doc/BRIEF.md
# Passive Serial Configuration Sequencer

This block loads a configuration bitstream into a downstream programmable device over a passive serial link, with no processor bit-banging pins. After a start pulse it pulls a board-level bus reset low and keeps it low. It then runs the device's configuration handshake: a long high period on the active-low config request, a short low pulse, a wait for the device's active-low status to drop, and a timed wait for status to rise again. Bitstream bytes then arrive on a valid/ready stream. Each byte is serialized least significant bit first, one bit per data clock. Two zero bytes are appended after the last byte.

Once the payload and padding are sent, the sequencer keeps clocking zeros until the device raises config-done. A timeout guards this phase. It then gives a fixed run of trailing clocks so the device enters user mode. The outcome is reported on `done` and on `err`/`err_code`, and both stay latched until the next start. All delays and timeouts are counted in system clocks. The data clock half-period comes from a divider of the system clock.

States: IDLE (waiting for start), PRE_HI (request high, long delay), PULSE_LO (request low, short delay), WAIT_LO (request low until status low), WAIT_HI (request high until status high, timed), LOAD (stream bytes), PAD (zero bytes), FLUSH (zero clocks until done, timed), TRAIL (trailing clocks). Transitions: IDLE→PRE_HI on start; PRE_HI→PULSE_LO after the long delay; PULSE_LO→WAIT_LO after the short delay; WAIT_LO→WAIT_HI when status is seen low; WAIT_HI→LOAD when status is seen high, or WAIT_HI→IDLE on status timeout; LOAD→PAD once the marked last byte has left the shifter; PAD→FLUSH when the padding is sent and the bit clock is idle; FLUSH→TRAIL when config-done is seen high, or FLUSH→IDLE on done timeout; TRAIL→IDLE after the trailing clocks.

Top module: `pscfg_seq`

## Requirements
- R1: After reset, and in the idle state, `busy`, `done`, `err`, `s_ready` and `cfg_clk` are 0, `err_code` is 2'b00, and `cfg_req_n` and `bus_rst_n` are 1.
- R2: `bus_rst_n` is 0 on every cycle in which `busy` is 1, and it is 1 when the block is idle.
- R3: A start pulse in the idle state raises `busy` on the next cycle. `cfg_req_n` then stays 1 for exactly LONG_DLY cycles. After that it is 0 for at least SHORT_DLY cycles.
- R4: `cfg_req_n` stays 0 until the synchronized `stat_n` has been seen 0, and it is released only after that.
- R5: After the release, if the synchronized `stat_n` is not seen 1 within STAT_TMO cycles, the block returns to idle with `err_code` = 2'b01 and `err` = 1, without producing a single `cfg_clk` rising edge.
- R6: Bits are sent least significant bit first, one per `cfg_clk` rising edge. `cfg_dat` changes only while `cfg_clk` is 0. Each `cfg_clk` high phase lasts exactly HALF_DIV cycles.
- R7: `s_ready` is 1 only in the load phase, only while the shifter is empty, and only before the byte marked by `s_last` has been accepted. A byte is accepted on a clock edge with `s_valid` and `s_ready` both 1.
- R8: After the last payload byte, PAD_BYTES bytes of 0x00 (default 2) are sent.
- R9: After the padding, zero bits are clocked while `cfg_done` is seen 0 at each bit boundary. If FLUSH lasts DONE_TMO cycles without `cfg_done`, the block returns to idle with `err_code` = 2'b10 and `err` = 1.
- R10: Once `cfg_done` is seen 1 at a bit boundary, exactly TRAIL_CLKS more rising edges (default 10) follow with `cfg_dat` = 0. The block then returns to idle with `done` = 1 and `err_code` = 2'b00.
- R11: A start pulse while `busy` is 1 is ignored. The running sequence completes normally, with a single config request pulse.
- R12: `done`, `err` and `err_code` hold their values while idle and are cleared by the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a configuration run when idle |
| s_data | input | DW | Bitstream byte |
| s_valid | input | 1 | Stream byte valid |
| s_last | input | 1 | Marks the final payload byte |
| s_ready | output | 1 | Stream ready; shifter empty in load phase |
| cfg_req_n | output | 1 | Active-low configuration request to the device |
| cfg_dat | output | 1 | Serial configuration data |
| cfg_clk | output | 1 | Serial data clock; device samples on rising edge |
| stat_n | input | 1 | Active-low status from the device (asynchronous) |
| cfg_done | input | 1 | Configuration-done from the device (asynchronous) |
| bus_rst_n | output | 1 | Board bus reset, held low while busy |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last run completed successfully |
| err | output | 1 | Last run failed |
| err_code | output | 2 | 00 none, 01 status timeout, 10 done timeout |

## Verification
Three corner cases get directed runs. First, the device holds status low forever. A sequencer that skipped the timed wait would start clocking data into an unready device, or would hang busy. Second, the device never raises done. A missing flush timeout would leave the block busy forever. Third, config-done rises on the very last padding bit. Sampling done too late there, or miscounting the tail, shows up as a trailing-clock count other than ten. Randomized payload lengths, stream gaps and status delays also catch an MSB-first or bit-slipped shifter, missing padding, and request pulses cut short. A start re-issued mid-load would show up as a second request pulse.

// File: rtl/pscfg_pkg.sv
package pscfg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE_HI,
        ST_PULSE_LO,
        ST_WAIT_LO,
        ST_WAIT_HI,
        ST_LOAD,
        ST_PAD,
        ST_FLUSH,
        ST_TRAIL
    } cfg_state_e;

    typedef enum logic [1:0] {
        ERR_NONE = 2'b00,
        ERR_STAT = 2'b01,
        ERR_DONE = 2'b10
    } cfg_err_e;

endpackage

// File: rtl/pscfg_tmr.sv
module pscfg_tmr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    // Saturating up-counter, restarted on every state change.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (cnt != {W{1'b1}})
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pscfg_bitclk.sv
module pscfg_bitclk #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic sclk,
    output logic busy
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic          act_q;
    logic          ph_q;
    logic [CW-1:0] cnt_q;

    // One bit period: HALF_DIV cycles low, then HALF_DIV cycles high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            ph_q  <= 1'b0;
            cnt_q <= '0;
        end else if (!act_q) begin
            if (go) begin
                act_q <= 1'b1;
                ph_q  <= 1'b0;
                cnt_q <= '0;
            end
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            if (!ph_q) begin
                ph_q <= 1'b1;
            end else begin
                ph_q  <= 1'b0;
                act_q <= 1'b0;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign sclk = ph_q;
    assign busy = act_q;
endmodule

// File: rtl/pscfg_shreg.sv
module pscfg_shreg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] din,
    input  logic          adv,
    output logic          bit_o,
    output logic          empty
);
    localparam int NW = $clog2(DW + 1);

    logic [DW-1:0] sh_q;
    logic [NW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= '0;
        end else if (load) begin
            sh_q   <= din;
            left_q <= NW'(DW);
        end else if (adv) begin
            sh_q   <= sh_q >> 1;
            left_q <= left_q - 1'b1;
        end
    end

    assign bit_o = sh_q[0];
    assign empty = (left_q == '0);
endmodule

// File: rtl/pscfg_seq.sv
module pscfg_seq
    import pscfg_pkg::*;
#(
    parameter int LONG_DLY   = 1000,
    parameter int SHORT_DLY  = 50,
    parameter int STAT_TMO   = 10000,
    parameter int DONE_TMO   = 100000,
    parameter int HALF_DIV   = 4,
    parameter int TRAIL_CLKS = 10,
    parameter int PAD_BYTES  = 2,
    parameter int DW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] s_data,
    input  logic          s_valid,
    input  logic          s_last,
    output logic          s_ready,
    output logic          cfg_req_n,
    output logic          cfg_dat,
    output logic          cfg_clk,
    input  logic          stat_n,
    input  logic          cfg_done,
    output logic          bus_rst_n,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [1:0]    err_code
);
    localparam int TMAX_A = (LONG_DLY > SHORT_DLY) ? LONG_DLY : SHORT_DLY;
    localparam int TMAX_B = (STAT_TMO > DONE_TMO) ? STAT_TMO : DONE_TMO;
    localparam int TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
    localparam int TW     = $clog2(TMAX + 1);
    localparam int RW     = $clog2(TRAIL_CLKS + 1);
    localparam int PW     = $clog2(PAD_BYTES + 1);
    localparam logic [TW-1:0] LONG_LIM  = TW'(LONG_DLY - 1);
    localparam logic [TW-1:0] SHORT_LIM = TW'(SHORT_DLY - 1);
    localparam logic [TW-1:0] STAT_LIM  = TW'(STAT_TMO - 1);
    localparam logic [TW-1:0] DONE_LIM  = TW'(DONE_TMO - 1);

    cfg_state_e    state_q, state_d;
    logic [1:0]    stat_sy, done_sy;
    logic          stat_s, done_s;
    logic [TW-1:0] tmr_cnt;
    logic          tmr_clr;
    logic          bc_busy, go, go_bit;
    logic          sh_bit, sh_empty, sh_ld, sh_adv, take;
    logic [DW-1:0] sh_din;
    logic          last_q;
    logic [PW-1:0] pad_q;
    logic [RW-1:0] trail_q;
    logic          fin_ok;
    cfg_err_e      fin_err, err_q;
    logic          done_q;
    logic          launch;

    // Two-flop synchronizers for the device's asynchronous outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_sy <= 2'b11;
            done_sy <= 2'b00;
        end else begin
            stat_sy <= {stat_sy[0], stat_n};
            done_sy <= {done_sy[0], cfg_done};
        end
    end
    assign stat_s = stat_sy[1];
    assign done_s = done_sy[1];

    pscfg_tmr #(.W(TW)) tmr_i (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .cnt(tmr_cnt)
    );

    pscfg_bitclk #(.HALF_DIV(HALF_DIV)) bitclk_i (
        .clk(clk), .rst_n(rst_n), .go(go), .sclk(cfg_clk), .busy(bc_busy)
    );

    pscfg_shreg #(.DW(DW)) shreg_i (
        .clk(clk), .rst_n(rst_n), .load(sh_ld), .din(sh_din),
        .adv(sh_adv), .bit_o(sh_bit), .empty(sh_empty)
    );

    // Next state and per-cycle strobes
    always_comb begin
        state_d = state_q;
        go      = 1'b0;
        go_bit  = 1'b0;
        sh_ld   = 1'b0;
        sh_din  = '0;
        sh_adv  = 1'b0;
        take    = 1'b0;
        fin_ok  = 1'b0;
        fin_err = ERR_NONE;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_PRE_HI;
            ST_PRE_HI:   if (tmr_cnt >= LONG_LIM) state_d = ST_PULSE_LO;
            ST_PULSE_LO: if (tmr_cnt >= SHORT_LIM) state_d = ST_WAIT_LO;
            ST_WAIT_LO:  if (!stat_s) state_d = ST_WAIT_HI;
            ST_WAIT_HI: begin
                if (stat_s) begin
                    state_d = ST_LOAD;
                end else if (tmr_cnt >= STAT_LIM) begin
                    state_d = ST_IDLE;
                    fin_err = ERR_STAT;
                end
            end
            ST_LOAD: begin
                if (sh_empty) begin
                    if (last_q) begin
                        state_d = ST_PAD;
                    end else if (s_valid) begin
                        take   = 1'b1;
                        sh_ld  = 1'b1;
                        sh_din = s_data;
                    end
                end else if (!bc_busy) begin
                    go     = 1'b1;
                    go_bit = sh_bit;
                    sh_adv = 1'b1;
                end
            end
            ST_PAD: begin
                if (sh_empty) begin
                    if (pad_q != '0) sh_ld = 1'b1;
                    else if (!bc_busy) state_d = ST_FLUSH;
                end else if (!bc_busy) begin
                    go     = 1'b1;
                    go_bit = sh_bit;
                    sh_adv = 1'b1;
                end
            end
            ST_FLUSH: begin
                if (!bc_busy) begin
                    if (done_s) begin
                        state_d = ST_TRAIL;
                    end else if (tmr_cnt >= DONE_LIM) begin
                        state_d = ST_IDLE;
                        fin_err = ERR_DONE;
                    end else begin
                        go = 1'b1;
                    end
                end
            end
            ST_TRAIL: begin
                if (!bc_busy) begin
                    if (trail_q == RW'(TRAIL_CLKS)) begin
                        state_d = ST_IDLE;
                        fin_ok  = 1'b1;
                    end else begin
                        go = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign tmr_clr = (state_d != state_q);
    assign launch  = (state_q == ST_IDLE) && start;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Moore outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        bus_rst_n = (state_q == ST_IDLE);
        cfg_req_n = !((state_q == ST_PULSE_LO) || (state_q == ST_WAIT_LO));
        s_ready   = (state_q == ST_LOAD) && sh_empty && !last_q;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_dat <= 1'b0;
            last_q  <= 1'b0;
            pad_q   <= '0;
            trail_q <= '0;
            done_q  <= 1'b0;
            err_q   <= ERR_NONE;
        end else begin
            if (launch) begin
                last_q  <= 1'b0;
                pad_q   <= PW'(PAD_BYTES);
                trail_q <= '0;
                done_q  <= 1'b0;
                err_q   <= ERR_NONE;
            end
            if (take && s_last) last_q <= 1'b1;
            if (sh_ld && state_q == ST_PAD) pad_q <= pad_q - 1'b1;
            if (go) cfg_dat <= go_bit;
            if (go && state_q == ST_TRAIL) trail_q <= trail_q + 1'b1;
            if (fin_ok) done_q <= 1'b1;
            if (fin_err != ERR_NONE) err_q <= fin_err;
        end
    end

    assign done     = done_q;
    assign err_code = err_q;
    assign err      = (err_q != ERR_NONE);
endmodule

// File: rtl/pscfg_seq_chk.sv
module pscfg_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       bus_rst_n,
    input logic       cfg_clk,
    input logic       cfg_dat,
    input logic       cfg_req_n,
    input logic       s_ready,
    input logic       done,
    input logic [1:0] err_code,
    input logic       stat_s
);
    // R2
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_clk) |-> !bus_rst_n);

    // R3
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R4
    rel_after_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cfg_req_n) && busy) |-> !$past(stat_s));

    // R6
    dat_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_clk && $past(cfg_clk)) |-> $stable(cfg_dat));

    // R7
    rdy_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (busy && cfg_req_n));

    // R12
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_code != 2'b11);

    // R10
    done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err_code == 2'b00 && !busy));
endmodule

bind pscfg_seq pscfg_seq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .bus_rst_n(bus_rst_n), .cfg_clk(cfg_clk), .cfg_dat(cfg_dat),
    .cfg_req_n(cfg_req_n), .s_ready(s_ready), .done(done),
    .err_code(err_code), .stat_s(stat_s)
);

// File: tb/pscfg_seq_tb_top.sv
`timescale 1ns/1ps
module pscfg_seq_tb_top;
    localparam int LONG_DLY  = 20;
    localparam int SHORT_DLY = 6;
    localparam int STAT_TMO  = 40;
    localparam int DONE_TMO  = 200;
    localparam int HALF_DIV  = 3;
    localparam int TRAIL     = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] s_data = '0;
    logic s_valid = 1'b0, s_last = 1'b0;
    logic s_ready, cfg_req_n, cfg_dat, cfg_clk, bus_rst_n, busy, done, err;
    logic [1:0] err_code;
    logic stat_n = 1'b1;
    logic cfg_done = 1'b0;

    always #2.5 clk = ~clk;

    pscfg_seq #(
        .LONG_DLY(LONG_DLY), .SHORT_DLY(SHORT_DLY), .STAT_TMO(STAT_TMO),
        .DONE_TMO(DONE_TMO), .HALF_DIV(HALF_DIV), .TRAIL_CLKS(TRAIL),
        .PAD_BYTES(2), .DW(8)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .s_data(s_data),
        .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
        .cfg_req_n(cfg_req_n), .cfg_dat(cfg_dat), .cfg_clk(cfg_clk),
        .stat_n(stat_n), .cfg_done(cfg_done), .bus_rst_n(bus_rst_n),
        .busy(busy), .done(done), .err(err), .err_code(err_code)
    );

    int n_chk = 0, n_err = 0;
    bit finished = 1'b0;

    // Device model state
    int  lo_dly = 0, hi_dly = 0, lo_cnt = 0, hi_cnt = 0;
    bit  st_hang = 1'b0, dn_hang = 1'b0;
    int  done_after = 0;
    int  bit_cnt = 0, post_edges = 0;
    bit  bits [0:1023];
    bit [7:0] pay [0:15];

    // Monitor counters
    int hi_run = 0, lo_run = 0, falls = 0, rst_viol = 0, rdy_viol = 0;
    int hi_bad = 0, clk_hi = 0;
    logic prev_req = 1'b1, prev_clk = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Status pin behaviour of the target
    always @(posedge clk) begin
        if (!cfg_req_n) begin
            hi_cnt <= 0;
            if (lo_cnt >= lo_dly) stat_n <= 1'b0;
            else lo_cnt <= lo_cnt + 1;
        end else begin
            lo_cnt <= 0;
            if (!stat_n && !st_hang) begin
                if (hi_cnt >= hi_dly) stat_n <= 1'b1;
                else hi_cnt <= hi_cnt + 1;
            end
        end
    end

    // Serial capture and config-done generation
    always @(posedge cfg_clk) begin
        if (cfg_done) post_edges = post_edges + 1;
        if (bit_cnt < 1024) bits[bit_cnt] = cfg_dat;
        bit_cnt = bit_cnt + 1;
        if (!dn_hang && !cfg_done && bit_cnt == done_after) cfg_done = 1'b1;
    end

    // Pin-level monitors, away from the active edge
    always @(negedge clk) begin
        if (busy && cfg_req_n && falls == 0) hi_run = hi_run + 1;
        if (!cfg_req_n) lo_run = lo_run + 1;
        if (prev_req && !cfg_req_n) falls = falls + 1;
        if (busy && bus_rst_n) rst_viol = rst_viol + 1;
        if (!busy && !bus_rst_n) rst_viol = rst_viol + 1;
        if (s_ready && (!busy || !cfg_req_n)) rdy_viol = rdy_viol + 1;
        if (cfg_clk) clk_hi = clk_hi + 1;
        if (prev_clk && !cfg_clk) begin
            if (clk_hi != HALF_DIV) hi_bad = hi_bad + 1;
            clk_hi = 0;
        end
        prev_req = cfg_req_n;
        prev_clk = cfg_clk;
    end

    function automatic int pay_mismatch(input int n);
        int m = 0;
        for (int k = 0; k < n; k++)
            for (int j = 0; j < 8; j++)
                if (bits[8*k+j] != pay[k][j]) m++;
        return m;
    endfunction

    function automatic int ones_between(input int lo, input int hi);
        int m = 0;
        for (int i = lo; i < hi && i < 1024; i++) if (bits[i]) m++;
        return m;
    endfunction

    // mode: 0 normal, 1 status hang, 2 done hang
    task automatic run_cfg(input int n, input int extra, input int ld, input int hd,
                           input int mode, input bit poke);
        int gap;
        while (!stat_n) @(negedge clk);
        @(negedge clk);
        lo_dly = ld; hi_dly = hd;
        st_hang = (mode == 1); dn_hang = (mode == 2);
        cfg_done = 1'b0; bit_cnt = 0; post_edges = 0;
        done_after = 8*n + 16 + extra;
        hi_run = 0; lo_run = 0; falls = 0; rst_viol = 0; rdy_viol = 0; hi_bad = 0;
        for (int k = 0; k < n; k++) pay[k] = 8'($urandom);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R3", "busy after start", busy, 1);
        chk(err_code == 2'b00, "R12", "code cleared by start", err_code, 0);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            s_valid = 1'b1; s_data = pay[k]; s_last = (k == n-1);
            while (!s_ready && busy) @(negedge clk);
            if (!busy) break;
            @(posedge clk);
            @(negedge clk);
            s_valid = 1'b0; s_last = 1'b0;
            if (poke && k == n/2) begin
                start = 1'b1; @(negedge clk); start = 1'b0;
            end
            gap = $urandom_range(0, 3);
            repeat (gap) @(negedge clk);
        end
        s_valid = 1'b0; s_last = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(rst_viol == 0, "R2", "bus reset vs busy", rst_viol, 0);
        chk(rdy_viol == 0, "R7", "ready outside load", rdy_viol, 0);
        chk(hi_run == LONG_DLY, "R3", "request high before pulse", hi_run, LONG_DLY);
        chk(lo_run >= SHORT_DLY + 1, "R3", "request low width", lo_run, SHORT_DLY + 1);
        chk(lo_run > ld, "R4", "request held until status low", lo_run, ld + 1);
        chk(cfg_req_n && bus_rst_n && !busy, "R1", "idle pins", {cfg_req_n, bus_rst_n, busy}, 3'b110);
        if (mode == 1) begin
            chk(err_code == 2'b01 && err && !done, "R5", "status timeout code", err_code, 1);
            chk(bit_cnt == 0, "R5", "no clocks on status timeout", bit_cnt, 0);
        end else begin
            chk(falls == 1, "R11", "request pulses", falls, 1);
            chk(pay_mismatch(n) == 0, "R6", "LSB-first payload bit errors", pay_mismatch(n), 0);
            chk(hi_bad == 0, "R6", "clock high width errors", hi_bad, 0);
            chk(ones_between(8*n, 8*n + 16) == 0, "R8", "pad bytes nonzero bits",
                ones_between(8*n, 8*n + 16), 0);
            if (mode == 2) begin
                chk(err_code == 2'b10 && err && !done, "R9", "done timeout code", err_code, 2);
                chk(bit_cnt > 8*n + 16, "R9", "flush clocks issued", bit_cnt, 8*n + 17);
            end else begin
                chk(ones_between(8*n + 16, bit_cnt) == 0, "R9", "flush/trail data",
                    ones_between(8*n + 16, bit_cnt), 0);
                chk(post_edges == TRAIL, "R10", "trailing clocks", post_edges, TRAIL);
                chk(bit_cnt == done_after + TRAIL, "R9", "total clocks", bit_cnt, done_after + TRAIL);
                chk(done && !err && err_code == 2'b00, "R10", "done flag", {done, err_code}, 4);
            end
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_c0de));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !err && err_code == 2'b00, "R1", "reset flags",
            {busy, done, err, err_code}, 0);
        chk(cfg_req_n && bus_rst_n && !s_ready && !cfg_clk, "R1", "reset pins",
            {cfg_req_n, bus_rst_n, s_ready, cfg_clk}, 4'b1100);

        run_cfg(1, 0, 0, 0, 0, 1'b0);          // done on last pad bit
        for (int it = 0; it < 5; it++)
            run_cfg($urandom_range(1, 8), $urandom_range(0, 4),
                    $urandom_range(0, 10), $urandom_range(0, 10), 0, 1'b0);
        run_cfg(8, 4, 10, 10, 0, 1'b0);        // longest payload
        run_cfg(4, 2, 3, 2, 0, 1'b1);          // start while busy (R11)

        run_cfg(3, 0, 2, 0, 1, 1'b0);          // status never high
        repeat (20) @(negedge clk);
        chk(err_code == 2'b01 && !busy, "R12", "status error held", err_code, 1);
        st_hang = 1'b0;

        run_cfg(2, 0, 1, 1, 2, 1'b0);          // done never high
        repeat (20) @(negedge clk);
        chk(err_code == 2'b10 && err, "R12", "done error held", err_code, 2);

        run_cfg(2, 1, 1, 1, 0, 1'b0);          // recovery after error

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule